// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the register-side face of a message-digest engine that can run MD5, SHA-1, SHA-224 or SHA-256. Software uses a plain 32-bit register bus to do four things. It pulses a soft reset. It programs the message length in bits, then writes a control word that picks the algorithm and the byte order of the returned digest. After that it reads the digest back one word at a time through a single popping address. Interrupt causes are latched in a status register, gated by an enable register and cleared by write-one-to-clear.

The data words come from a separate write-port block and arrive on a valid/ready word stream. Only the handshake is seen here: the front-end counts words and never looks at their contents. `din_ready` stays low during the settling gap after a control write and after the programmed length has been taken, so the data port must hold `din_valid` until it is accepted. Before the engine is configured, `din_ready` is high so that stray words drain away, and each such word is flagged as an error. The hashing rounds are replaced by a stub. Once the last word is in, the stub waits a fixed latency and then fills the result queue with a recognisable pattern.

Top module: `hashfe_top`

## Requirements
- R1: Writing 1 to bit 0 at offset 0x00 holds the engine cleared, and writing 0 releases it. While the engine is held, the length, control, status, enable, result queue and word sequencing are all zero or idle. Offset 0x00 reads back the held bit.
- R2: Offset 0x04 holds the upper 32 bits of the message length in bits and offset 0x08 the lower 32 bits; both read back as written. Control at 0x0C keeps the algorithm code in bits [1:0] and the byte-order code in bits [9:8]. Every other control bit reads 0.
- R3: After a control write, exactly ceil(length/32) words are accepted, after which `din_ready` goes low. A zero length needs no words at all.
- R4: `din_ready` is low in the two cycles that follow the clock edge taking a control write. The first word can be accepted at the third edge at the earliest.
- R5: Reading offset 0x1C pops one digest word, highest index first and index 0 last. Digest word i has the layout {8'hD1, 2'b00, alg[1:0], N[3:0], 8'h5A, 4'h0, i[3:0]}, where N is the word count of the algorithm.
- R6: The queue holds N words: 4 for algorithm code 0 (MD5), 5 for code 1 (SHA-1), 7 for code 2 (SHA-224) and 8 for code 3 (SHA-256).
- R7: A read of 0x1C while the queue is empty returns 0 and sets status bit 2.
- R8: A word offered before any control write since reset is taken with `din_ready` high, dropped without being counted, and sets status bit 3.
- R9: Byte-order code 0 returns digest words unchanged. Code 1 reverses all four bytes. Code 2 returns the bytes [23:16],[31:24],[15:8],[7:0]. Code 3 returns [15:8],[7:0],[31:24],[23:16].
- R10: Status is read at 0x10 and enable at 0x14. Writing to 0x18 clears each status bit written as 1 and leaves those written as 0. `irq` is the OR of the status bits ANDed with the enable bits. A status bit that is set and cleared in the same cycle ends up set.
- R11: Status bit 0 sets when the last word is accepted, or at the end of the gap for a zero length. Status bit 1 sets when the digest reaches the queue, STUB_LATENCY cycles later.
- R12: Offset 0x50 returns the REVISION parameter. Reads of unmapped offsets return 0 and pop nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access |
| din_valid | input | 1 | A data word is offered by the write port |
| din_ready | output | 1 | The offered word is taken at this edge |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that the bus never accesses the queue and the control register in the same cycle; one strobe per cycle guarantees this. They also assume GAP_CYCLES stays at its default of two. The bench drives one access at a time from a single process and sets the bus and stream inputs only at falling edges. Once valid is raised, it stays up until a word is taken. Every job starts with a soft reset, just as software would.

// File: rtl/hashfe_pkg.sv
package hashfe_pkg;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } hash_alg_e;

  typedef enum logic [2:0] {
    PH_UNCFG,
    PH_GAP,
    PH_FEED,
    PH_CRUNCH,
    PH_DONE
  } phase_e;

  // Register offsets (software-visible map)
  localparam logic [7:0] OFS_RESET  = 8'h00;
  localparam logic [7:0] OFS_LEN_HI = 8'h04;
  localparam logic [7:0] OFS_LEN_LO = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_ENAB   = 8'h14;
  localparam logic [7:0] OFS_CLR    = 8'h18;
  localparam logic [7:0] OFS_RESULT = 8'h1C;
  localparam logic [7:0] OFS_REV    = 8'h50;

  localparam int IRQ_BITS   = 4;
  localparam int IRQ_AVAIL  = 0;
  localparam int IRQ_NEWRES = 1;
  localparam int IRQ_RDERR  = 2;
  localparam int IRQ_WRERR  = 3;

  function automatic logic [3:0] digest_words(hash_alg_e a);
    case (a)
      ALG_MD5:    return 4'd4;
      ALG_SHA1:   return 4'd5;
      ALG_SHA224: return 4'd7;
      default:    return 4'd8;
    endcase
  endfunction

  function automatic logic [31:0] stub_word(hash_alg_e a, logic [3:0] idx);
    return {8'hD1, 2'b00, a, digest_words(a), 8'h5A, 4'h0, idx};
  endfunction

  function automatic logic [31:0] order_bytes(logic [31:0] w, logic [1:0] code);
    case (code)
      2'd0:    return w;
      2'd1:    return {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'd2:    return {w[23:16], w[31:24], w[15:8], w[7:0]};
      default: return {w[15:8], w[7:0], w[31:24], w[23:16]};
    endcase
  endfunction

endpackage

// File: rtl/hashfe_seq.sv
// Word sequencer plus the stand-in for the hashing rounds.
module hashfe_seq
  import hashfe_pkg::*;
#(
  parameter int LEN_W        = 64,
  parameter int GAP_CYCLES   = 2,
  parameter int STUB_LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_clr,
  input  logic             ctrl_wr,
  input  logic [LEN_W-1:0] len_bits,
  input  logic             din_valid,
  output logic             din_ready,
  output logic             cfg_done,
  output logic             wr_err,
  output logic             consumed,
  output logic             push
);
  localparam int CNT_W = LEN_W - 4;
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int LAT_W = $clog2(STUB_LATENCY + 1);

  phase_e           phase;
  logic [CNT_W-1:0] words_left;
  logic [GAP_W-1:0] gap_cnt;
  logic [LAT_W-1:0] lat_cnt;
  logic [LEN_W:0]   len_round;
  logic [CNT_W-1:0] word_total;
  logic             live;

  assign len_round  = {1'b0, len_bits} + (LEN_W + 1)'(31);
  assign word_total = len_round[LEN_W:5];
  assign live       = !eng_clr && !ctrl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_UNCFG;
      words_left <= '0;
      gap_cnt    <= '0;
      lat_cnt    <= '0;
    end else if (eng_clr) begin
      phase      <= PH_UNCFG;
      words_left <= '0;
      gap_cnt    <= '0;
      lat_cnt    <= '0;
    end else if (ctrl_wr) begin
      phase      <= PH_GAP;
      gap_cnt    <= GAP_W'(GAP_CYCLES);
      words_left <= word_total;
    end else begin
      case (phase)
        PH_GAP: begin
          if (gap_cnt == GAP_W'(1)) begin
            if (words_left == '0) begin
              phase   <= PH_CRUNCH;
              lat_cnt <= LAT_W'(STUB_LATENCY);
            end else begin
              phase <= PH_FEED;
            end
          end else begin
            gap_cnt <= gap_cnt - GAP_W'(1);
          end
        end
        PH_FEED: begin
          if (din_valid) begin
            words_left <= words_left - CNT_W'(1);
            if (words_left == CNT_W'(1)) begin
              phase   <= PH_CRUNCH;
              lat_cnt <= LAT_W'(STUB_LATENCY);
            end
          end
        end
        PH_CRUNCH: begin
          if (lat_cnt == LAT_W'(1)) phase <= PH_DONE;
          else lat_cnt <= lat_cnt - LAT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    din_ready = !eng_clr && ((phase == PH_UNCFG) || (phase == PH_FEED && !ctrl_wr));
    cfg_done  = (phase != PH_UNCFG);
    wr_err    = !eng_clr && (phase == PH_UNCFG) && din_valid;
    consumed  = live && ((phase == PH_GAP && gap_cnt == GAP_W'(1) && words_left == '0) ||
                         (phase == PH_FEED && din_valid && words_left == CNT_W'(1)));
    push      = live && (phase == PH_CRUNCH) && (lat_cnt == LAT_W'(1));
  end

endmodule

// File: rtl/hashfe_rq.sv
// Result queue: filled in one cycle, popped from the top index down.
module hashfe_rq
  import hashfe_pkg::*;
#(
  parameter int MAX_WORDS = 8,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  hash_alg_e        alg,
  input  logic [1:0]       order,
  input  logic             pop,
  output logic [31:0]      rd_word,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam int IDX_W = $clog2(MAX_WORDS);

  logic [31:0]      slot [MAX_WORDS];
  logic [CNT_W-1:0] fill_n;
  logic [IDX_W-1:0] top_idx;

  assign fill_n  = CNT_W'(digest_words(alg));
  assign top_idx = IDX_W'(count - CNT_W'(1));

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot[g] <= '0;
      else if (clr)  slot[g] <= '0;
      else if (push) slot[g] <= (CNT_W'(g) < fill_n) ? stub_word(alg, 4'(g)) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (clr)                 count <= '0;
    else if (push)                count <= fill_n;
    else if (pop && count != '0)  count <= count - CNT_W'(1);
  end

  assign empty   = (count == '0);
  assign rd_word = empty ? '0 : order_bytes(slot[top_idx], order);

endmodule

// File: rtl/hashfe_irq.sv
// Latched interrupt causes with enable mask and write-one-to-clear.
module hashfe_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eng_clr,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_data,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] wipe;

  assign wipe = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else if (eng_clr) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~wipe) | set;
      if (en_wr) enable <= en_data;
    end
  end

  assign irq = |(status & enable);

endmodule

// File: rtl/hashfe_top.sv
module hashfe_top
  import hashfe_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          MAX_WORDS    = 8,
  parameter int          GAP_CYCLES   = 2,
  parameter int          STUB_LATENCY = 4,
  parameter logic [31:0] REVISION     = 32'h0002_0104
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              din_valid,
  output logic              din_ready,
  output logic              irq
);
  localparam int LEN_W = 64;
  localparam int QC_W  = $clog2(MAX_WORDS + 1);

  logic            soft_rst;
  logic [31:0]     len_hi, len_lo;
  hash_alg_e       ctrl_alg;
  logic [1:0]      ctrl_order;

  logic            wr_en, rd_en;
  logic            ctrl_wr, q_pop, rd_err;
  logic            en_wr, clr_wr;
  logic            cfg_done, wr_err, consumed, stub_push;
  logic [31:0]     q_word;
  logic            q_empty;
  logic [QC_W-1:0] q_count;
  logic [IRQ_BITS-1:0] irq_status, irq_enable, irq_set;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_en   = reg_sel && reg_wr;
  assign rd_en   = reg_sel && !reg_wr;
  assign ctrl_wr = wr_en && hit(reg_addr, OFS_CTRL) && !soft_rst;
  assign en_wr   = wr_en && hit(reg_addr, OFS_ENAB) && !soft_rst;
  assign clr_wr  = wr_en && hit(reg_addr, OFS_CLR)  && !soft_rst;
  assign q_pop   = rd_en && hit(reg_addr, OFS_RESULT) && !soft_rst;
  assign rd_err  = q_pop && q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst   <= 1'b0;
      len_hi     <= '0;
      len_lo     <= '0;
      ctrl_alg   <= ALG_MD5;
      ctrl_order <= '0;
    end else begin
      if (wr_en && hit(reg_addr, OFS_RESET)) soft_rst <= reg_wdata[0];
      if (soft_rst) begin
        len_hi     <= '0;
        len_lo     <= '0;
        ctrl_alg   <= ALG_MD5;
        ctrl_order <= '0;
      end else if (wr_en) begin
        if (hit(reg_addr, OFS_LEN_HI)) len_hi <= reg_wdata;
        if (hit(reg_addr, OFS_LEN_LO)) len_lo <= reg_wdata;
        if (hit(reg_addr, OFS_CTRL)) begin
          ctrl_alg   <= hash_alg_e'(reg_wdata[1:0]);
          ctrl_order <= reg_wdata[9:8];
        end
      end
    end
  end

  hashfe_seq #(
    .LEN_W       (LEN_W),
    .GAP_CYCLES  (GAP_CYCLES),
    .STUB_LATENCY(STUB_LATENCY)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_clr  (soft_rst),
    .ctrl_wr  (ctrl_wr),
    .len_bits ({len_hi, len_lo}),
    .din_valid(din_valid),
    .din_ready(din_ready),
    .cfg_done (cfg_done),
    .wr_err   (wr_err),
    .consumed (consumed),
    .push     (stub_push)
  );

  hashfe_rq #(.MAX_WORDS(MAX_WORDS)) u_rq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_rst),
    .push   (stub_push),
    .alg    (ctrl_alg),
    .order  (ctrl_order),
    .pop    (q_pop),
    .rd_word(q_word),
    .empty  (q_empty),
    .count  (q_count)
  );

  always_comb begin
    irq_set             = '0;
    irq_set[IRQ_AVAIL]  = consumed;
    irq_set[IRQ_NEWRES] = stub_push;
    irq_set[IRQ_RDERR]  = rd_err;
    irq_set[IRQ_WRERR]  = wr_err;
  end

  hashfe_irq #(.N(IRQ_BITS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .eng_clr (soft_rst),
    .set     (irq_set),
    .clr_wr  (clr_wr),
    .clr_mask(reg_wdata[IRQ_BITS-1:0]),
    .en_wr   (en_wr),
    .en_data (reg_wdata[IRQ_BITS-1:0]),
    .status  (irq_status),
    .enable  (irq_enable),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd_en) begin
      if (hit(reg_addr, OFS_RESET))  reg_rdata = {31'b0, soft_rst};
      if (hit(reg_addr, OFS_LEN_HI)) reg_rdata = len_hi;
      if (hit(reg_addr, OFS_LEN_LO)) reg_rdata = len_lo;
      if (hit(reg_addr, OFS_CTRL))   reg_rdata = {22'b0, ctrl_order, 6'b0, ctrl_alg};
      if (hit(reg_addr, OFS_STAT))   reg_rdata = {{(32-IRQ_BITS){1'b0}}, irq_status};
      if (hit(reg_addr, OFS_ENAB))   reg_rdata = {{(32-IRQ_BITS){1'b0}}, irq_enable};
      if (hit(reg_addr, OFS_RESULT)) reg_rdata = q_word;
      if (hit(reg_addr, OFS_REV))    reg_rdata = REVISION;
    end
  end

endmodule

// File: rtl/hashfe_chk.sv
module hashfe_chk #(
  parameter int MAX_WORDS = 8,
  localparam int QC_W     = $clog2(MAX_WORDS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            soft_rst,
  input logic            ctrl_wr,
  input logic            din_valid,
  input logic            din_ready,
  input logic            cfg_done,
  input logic            q_pop,
  input logic            q_empty,
  input logic            stub_push,
  input logic [QC_W-1:0] q_count,
  input logic [3:0]      irq_status,
  input logic            irq
);

  assert_gap_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !din_ready);

  assert_gap_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_wr) |=> !din_ready);

  assert_pop_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && !q_empty && !stub_push && !soft_rst) |=> (q_count == $past(q_count) - QC_W'(1)));

  assert_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QC_W'(MAX_WORDS));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && q_empty) |=> irq_status[2]);

  assert_early_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && !cfg_done && !soft_rst) |=> irq_status[3]);

  assert_soft_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && $past(soft_rst)) |-> (!irq && q_empty));

endmodule

bind hashfe_top hashfe_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .ctrl_wr   (ctrl_wr),
  .din_valid (din_valid),
  .din_ready (din_ready),
  .cfg_done  (cfg_done),
  .q_pop     (q_pop),
  .q_empty   (q_empty),
  .stub_push (stub_push),
  .q_count   (q_count),
  .irq_status(irq_status),
  .irq       (irq)
);

// File: tb/sim_hashfe_top.sv
`timescale 1ns/1ps
module sim_hashfe_top;
  localparam logic [31:0] REV = 32'h0002_0104;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  hashfe_top #(.REVISION(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .din_valid(din_valid), .din_ready(din_ready), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 0;
  endtask

  function automatic int exp_n(logic [1:0] alg);
    case (alg) 2'd0: return 4; 2'd1: return 5; 2'd2: return 7; default: return 8; endcase
  endfunction

  function automatic logic [31:0] exp_word(logic [1:0] alg, int i, logic [1:0] ord);
    logic [31:0] w;
    logic [3:0] n = 4'(exp_n(alg));
    w = {8'hD1, 2'b00, alg, n, 8'h5A, 4'h0, 4'(i)};
    case (ord)
      2'd0: return w;
      2'd1: return {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'd2: return {w[23:16], w[31:24], w[15:8], w[7:0]};
      default: return {w[15:8], w[7:0], w[31:24], w[23:16]};
    endcase
  endfunction

  // Driver: one full job; pushes the expected readout into the scoreboard.
  task automatic run_job(logic [1:0] alg, logic [1:0] ord, logic [63:0] nbits, logic [3:0] en);
    logic [31:0] v;
    longint words = longint'((nbits + 64'd31) >> 5);
    longint sent = 0;
    int guard = 0;
    bw(8'h00, 1); bw(8'h00, 0);
    bw(8'h14, {28'b0, en});
    bw(8'h04, nbits[63:32]); bw(8'h08, nbits[31:0]);
    bw(8'h0C, {22'b0, ord, 6'b0, alg});
    chk("R4 gap cycle 1", {31'b0, din_ready}, 0);
    @(negedge clk);
    chk("R4 gap cycle 2", {31'b0, din_ready}, 0);
    if (words > 0) begin
      while (sent < words && guard < 1000) begin
        @(negedge clk);
        din_valid = 1;
        if (sent == 0) chk("R4 ready after gap", {31'b0, din_ready}, 1);
        if (din_ready) sent++;
        guard++;
      end
      @(negedge clk);
      din_valid = 0;
      chk("R3 ready drops after last word", {31'b0, din_ready}, 0);
      br(8'h10, v);
      chk("R11 bit0 before bit1", v & 32'h3, 32'h1);
    end
    guard = 0;
    while (!irq && guard < 50) begin @(negedge clk); guard++; end
    chk("R11 digest within latency", {31'b0, guard <= 8}, 1);
    br(8'h10, v);
    chk("R11 new results set", v & 32'h3, 32'h3);
    for (int i = exp_n(alg) - 1; i >= 0; i--) exp_q.push_back(exp_word(alg, i, ord));
  endtask

  // Monitor: pops the queue and compares against the scoreboard.
  task automatic drain(string req);
    logic [31:0] v, e;
    while (exp_q.size() > 0) begin
      br(8'h1C, v);
      e = exp_q.pop_front();
      chk(req, v, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state, revision, unmapped
    chk("R10 irq at reset", {31'b0, irq}, 0);
    br(8'h10, v); chk("R10 status at reset", v, 0);
    br(8'h50, v); chk("R12 revision", v, REV);
    br(8'h24, v); chk("R12 unmapped reads 0", v, 0);

    // R8: data before configuration
    bw(8'h14, 32'h8);
    @(negedge clk); din_valid = 1;
    chk("R8 early word taken", {31'b0, din_ready}, 1);
    @(negedge clk); din_valid = 0;
    br(8'h10, v); chk("R8 write error bit3", v, 32'h8);
    chk("R10 irq on enabled bit", {31'b0, irq}, 1);
    bw(8'h18, 32'h0);
    br(8'h10, v); chk("R10 clear with zeros keeps", v, 32'h8);
    bw(8'h18, 32'h8);
    br(8'h10, v); chk("R10 clear with one", v, 0);
    chk("R10 irq after clear", {31'b0, irq}, 0);

    // R2 readback
    bw(8'h04, 32'hCAFE_0001); bw(8'h08, 32'h1234_5678);
    br(8'h04, v); chk("R2 length high", v, 32'hCAFE_0001);
    br(8'h08, v); chk("R2 length low", v, 32'h1234_5678);
    bw(8'h0C, 32'hFFFF_FFFF);
    br(8'h0C, v); chk("R2 control masked", v, 32'h0000_0303);

    // R5 R6 jobs for each algorithm
    run_job(2'd0, 2'd0, 64'd128, 4'h2); drain("R6 MD5 four words R5");
    br(8'h1C, v); chk("R7 empty read returns 0", v, 0);
    br(8'h10, v); chk("R7 read error bit2", v & 32'h4, 32'h4);
    run_job(2'd1, 2'd0, 64'd160, 4'h2); drain("R6 SHA1 five words");
    run_job(2'd2, 2'd1, 64'd33, 4'h2);  drain("R9 order code1 SHA224");
    run_job(2'd3, 2'd2, 64'd0, 4'h2);   drain("R9 order code2 zero length R3");
    run_job(2'd3, 2'd3, 64'd1000, 4'h2);

    // R12: unmapped reads do not pop
    br(8'h1D, v); chk("R12 unaligned unmapped", v, 0);
    br(8'h20, v); chk("R12 unmapped 0x20", v, 0);
    drain("R9 order code3 SHA256 R5");

    // R10 masking: only bit1 enabled
    run_job(2'd1, 2'd0, 64'd64, 4'h2);
    bw(8'h18, 32'h2);
    chk("R10 masked bit0 gives no irq", {31'b0, irq}, 0);
    br(8'h10, v); chk("R10 bit0 still latched", v, 32'h1);

    // R1 soft reset clears queue and registers
    bw(8'h00, 1);
    br(8'h00, v); chk("R1 reset readback", v, 1);
    bw(8'h00, 0);
    br(8'h08, v); chk("R1 length cleared", v, 0);
    br(8'h14, v); chk("R1 enable cleared", v, 0);
    br(8'h1C, v); chk("R1 queue emptied", v, 0);
    exp_q.delete();
    @(negedge clk); din_valid = 1;
    chk("R1 unconfigured after reset", {31'b0, din_ready}, 1);
    @(negedge clk); din_valid = 0;
    br(8'h10, v); chk("R1 R8 error after release", v & 32'h8, 32'h8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule